// File: doc/BRIEF.md
# External Trigger Clocked Counter

This block is a 16-bit timer counter that can be stepped by a conditioned external trigger instead of by every kernel clock cycle. One of sixteen trigger lines is chosen by a source index. It may be inverted, and it is then brought into the kernel clock domain through a two-flop synchronizer. After that, a power-of-two edge prescaler thins out the edges and an optional run-length filter rejects short glitches. Each rising edge of the resulting level produces a single-cycle count enable.

When the external mode is off, the counter simply steps once per kernel clock while enabled. The control fields are plain level inputs that are meant to be driven from a register bank elsewhere. The configuration should be changed only while the counter is disabled. Every trigger edge goes through a synchronizer and several registers, so each count lags its trigger edge by a few cycles. A trigger that toggles faster than one quarter of the kernel clock rate is not guaranteed to be counted.

Top module: `ext_trig_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0, and it reads 0 after reset is released.
- R2: With `cnt_en`=1 and `ext_mode`=0, `count` increases by exactly one on every kernel clock edge.
- R3: With `cnt_en`=0, `count` holds its value whatever the trigger inputs and the other controls do.
- R4: With `cnt_en`=1 and `ext_mode`=1, `count` increases by one for each rising edge of the conditioned trigger and is otherwise unchanged.
- R5: `src_sel` (values 0 to 15) selects `trig_in[src_sel]` as the trigger. Activity on any other line leaves `count` unchanged.
- R6: `psc_code` 2'b00, 2'b01, 2'b10 and 2'b11 give one count per 1, 2, 4 and 8 trigger rising edges. Whenever the code changes, the edge tally and the divided level are cleared, so the first count comes on the Nth edge after the change.
- R7: `flt_code`=0 passes the prescaled level through unfiltered. A nonzero code makes the filtered level change only after 2×`flt_code` consecutive kernel-clock samples that differ from it. Shorter pulses produce no count.
- R8: `count` is 16 bits wide and wraps from 16'hFFFF to 16'h0000.
- R9: With `psc_code`=0 and `flt_code`=0, a trigger rise that is first sampled at clock edge k changes `count` at edge k+4 and not before. Each conditioned rising edge gives a count-enable pulse exactly one cycle long.
- R10: `trig_inv`=1 inverts the selected line before the synchronizer, so counts follow its falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 16 | Candidate trigger lines |
| src_sel | input | 4 | Index of the trigger line in use |
| trig_inv | input | 1 | 1 inverts the selected trigger |
| psc_code | input | 2 | Edge prescale code: divide by 1, 2, 4 or 8 |
| flt_code | input | 4 | Filter run-length code, 0 = no filter |
| ext_mode | input | 1 | 1 = count conditioned trigger edges, 0 = count clock cycles |
| cnt_en | input | 1 | Counter enable |
| count | output | 16 | Counter value |

## Verification
The assertions assume that the prescale code only changes with the trigger idle and the counter disabled, and that a trigger level is held for at least two kernel cycles, keeping it within the quarter-rate limit. The stimulus honours both conditions. Every trigger pulse lasts at least four cycles high and four low, except for the deliberate short pulses used to exercise the filter. Every change to the source, polarity, prescale or filter field is made with `cnt_en` low and is followed by a settling gap, so the spurious edges a reconfiguration can create are never counted.

// File: rtl/etc_pkg.sv
`timescale 1ns/1ps
package etc_pkg;
    parameter int unsigned ETC_SRC_NUM = 16;
    parameter int unsigned ETC_CNT_W   = 16;
    parameter int unsigned ETC_PSC_W   = 2;
    parameter int unsigned ETC_FLT_W   = 4;

    typedef enum logic [1:0] {
        PSC_DIV1 = 2'b00,
        PSC_DIV2 = 2'b01,
        PSC_DIV4 = 2'b10,
        PSC_DIV8 = 2'b11
    } psc_e;
endpackage

// File: rtl/etc_trig_front.sv
`timescale 1ns/1ps
module etc_trig_front #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned SEL_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig_in,
    input  logic [SEL_W-1:0]   sel,
    input  logic               inv,
    output logic               sync_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } front_t;

    front_t st_d, st_q;
    logic   picked;

    // Source mux and optional inversion, then a two-stage synchronizer
    always_comb begin
        picked  = trig_in[sel] ^ inv;
        st_d.s1 = picked;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/etc_prescaler.sv
`timescale 1ns/1ps
module etc_prescaler
    import etc_pkg::*;
#(
    parameter int unsigned PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] code,
    input  logic             lvl_i,
    output logic             div_o
);
    localparam int unsigned MAX_DIV = 1 << ((1 << PSC_W) - 1);
    localparam int unsigned EDGE_W  = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    typedef struct packed {
        logic              prev;
        logic [PSC_W-1:0]  code;
        logic [EDGE_W-1:0] edges;
        logic              div;
    } psc_t;

    psc_t              st_d, st_q;
    logic              rise;
    logic [EDGE_W-1:0] last;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        st_d.code = code;
        rise      = lvl_i & ~st_q.prev;
        last      = EDGE_W'((32'd1 << code) - 32'd1);
        if (code != st_q.code) begin
            // A rewritten code restarts the tally from a known phase
            st_d.edges = '0;
            st_d.div   = 1'b0;
        end else if (code == PSC_W'(PSC_DIV1)) begin
            st_d.div   = lvl_i;
        end else if (rise) begin
            if (st_q.edges == last) begin
                st_d.edges = '0;
                st_d.div   = 1'b1;
            end else begin
                st_d.edges = st_q.edges + EDGE_W'(1);
                st_d.div   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_o = st_q.div;
endmodule

// File: rtl/etc_filter.sv
`timescale 1ns/1ps
module etc_filter #(
    parameter int unsigned FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLT_W-1:0] code,
    input  logic             lvl_i,
    output logic             lvl_o
);
    localparam int unsigned MAX_RUN = 2 * ((1 << FLT_W) - 1);
    localparam int unsigned RUN_W   = $clog2(MAX_RUN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             out;
    } flt_t;

    flt_t             st_d, st_q;
    logic [RUN_W-1:0] need;

    always_comb begin
        st_d = st_q;
        need = RUN_W'({code, 1'b0});
        if (code == '0) begin
            st_d.out = lvl_i;
            st_d.run = '0;
        end else if (lvl_i == st_q.out) begin
            st_d.run = '0;
        end else if ((st_q.run + RUN_W'(1)) >= need) begin
            st_d.out = lvl_i;
            st_d.run = '0;
        end else begin
            st_d.run = st_q.run + RUN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.out;
endmodule

// File: rtl/etc_counter.sv
`timescale 1ns/1ps
module etc_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic             ext_mode,
    input  logic             cnt_en,
    output logic             pulse_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t st_d, st_q;
    logic pulse;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        pulse     = lvl_i & ~st_q.prev;
        if (cnt_en) begin
            if (ext_mode) st_d.count = st_q.count + CNT_W'(pulse);
            else          st_d.count = st_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = pulse;
    assign count_o = st_q.count;
endmodule

// File: rtl/ext_trig_counter.sv
`timescale 1ns/1ps
module ext_trig_counter
    import etc_pkg::*;
#(
    parameter int unsigned NUM_SRC = ETC_SRC_NUM,
    parameter int unsigned SEL_W   = $clog2(NUM_SRC),
    parameter int unsigned CNT_W   = ETC_CNT_W,
    parameter int unsigned PSC_W   = ETC_PSC_W,
    parameter int unsigned FLT_W   = ETC_FLT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig_in,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               trig_inv,
    input  logic [PSC_W-1:0]   psc_code,
    input  logic [FLT_W-1:0]   flt_code,
    input  logic               ext_mode,
    input  logic               cnt_en,
    output logic [CNT_W-1:0]   count
);
    logic sync_lvl;
    logic div_lvl;
    logic flt_lvl;
    logic cnt_pulse;

    etc_trig_front #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .sel     (src_sel),
        .inv     (trig_inv),
        .sync_o  (sync_lvl)
    );

    etc_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (psc_code),
        .lvl_i (sync_lvl),
        .div_o (div_lvl)
    );

    etc_filter #(.FLT_W(FLT_W)) u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (flt_code),
        .lvl_i (div_lvl),
        .lvl_o (flt_lvl)
    );

    etc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (flt_lvl),
        .ext_mode (ext_mode),
        .cnt_en   (cnt_en),
        .pulse_o  (cnt_pulse),
        .count_o  (count)
    );
endmodule

// File: rtl/etc_checker.sv
`timescale 1ns/1ps
module etc_checker #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PSC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             ext_mode,
    input logic [PSC_W-1:0] psc_code,
    input logic             pulse,
    input logic             div_lvl,
    input logic [CNT_W-1:0] count
);
    p_int_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !ext_mode) |=> (count == $past(count) + CNT_W'(1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count));

    p_ext_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && ext_mode) |=> (count == $past(count) + CNT_W'($past(pulse))));

    p_psc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_code != $past(psc_code)) |=> !div_lvl);

    p_one_cycle_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

bind ext_trig_counter etc_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .ext_mode (ext_mode),
    .psc_code (psc_code),
    .pulse    (cnt_pulse),
    .div_lvl  (div_lvl),
    .count    (count)
);

// File: tb/ext_trig_counter_test.sv
`timescale 1ns/1ps
module ext_trig_counter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] trig_in;
    logic [3:0]  src_sel;
    logic        trig_inv;
    logic [1:0]  psc_code;
    logic [3:0]  flt_code;
    logic        ext_mode;
    logic        cnt_en;
    logic [15:0] count;

    always #4 clk = ~clk;

    ext_trig_counter uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .src_sel(src_sel),
        .trig_inv(trig_inv), .psc_code(psc_code), .flt_code(flt_code),
        .ext_mode(ext_mode), .cnt_en(cnt_en), .count(count)
    );

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    int    model  = 0;
    bit    done   = 1'b0;

    // Monitor: compares each expected item against the port when it arrives
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            begin
                item_t it;
                it = exp_q.pop_front();
                n_chk++;
                if (count !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: count actual %h expected %h", it.tag, count, it.exp);
                end
            end
        end
    end

    task automatic expect_cnt(input string tag);
        item_t it;
        it.exp = 16'(model);
        it.tag = tag;
        exp_q.push_back(it);
        #1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int idx, input int num, input int hi, input int lo);
        for (int i = 0; i < num; i++) begin
            trig_in[idx] = 1'b1;
            step(hi);
            trig_in[idx] = 1'b0;
            step(lo);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; trig_in = '0; src_sel = '0; trig_inv = 1'b0;
        psc_code = 2'b00; flt_code = 4'd0; ext_mode = 1'b0; cnt_en = 1'b0;
        step(3);
        expect_cnt("R1 in reset");
        rst_n = 1'b1;
        step(2);
        expect_cnt("R1 after reset");

        // R2: internal clock counting for 20 cycles
        cnt_en = 1'b1;
        step(20);
        cnt_en = 1'b0;
        model += 20;
        step(2);
        expect_cnt("R2 internal mode");

        // R3: disabled counter ignores triggers
        ext_mode = 1'b1;
        pulses(0, 4, 4, 4);
        step(8);
        expect_cnt("R3 hold while disabled");

        // R4: one count per rising edge
        cnt_en = 1'b1;
        pulses(0, 5, 4, 4);
        step(8);
        cnt_en = 1'b0;
        model += 5;
        expect_cnt("R4 external edges");

        // R9: exact latency, count changes at the 5th edge after driving
        cnt_en = 1'b1;
        trig_in[0] = 1'b1;
        step(4);
        expect_cnt("R9 no count before edge k+4");
        step(1);
        model += 1;
        expect_cnt("R9 count at edge k+4");
        trig_in[0] = 1'b0;
        step(6);
        cnt_en = 1'b0;

        // R5: source selection
        src_sel = 4'd5;
        step(6);
        cnt_en = 1'b1;
        pulses(0, 3, 4, 4);
        step(8);
        expect_cnt("R5 unselected line ignored");
        pulses(5, 3, 4, 4);
        step(8);
        cnt_en = 1'b0;
        model += 3;
        expect_cnt("R5 selected line counted");

        // R10: inversion counts falling edges of the raw line
        trig_inv = 1'b1;
        step(8);
        cnt_en = 1'b1;
        pulses(5, 3, 4, 4);
        step(8);
        cnt_en = 1'b0;
        model += 3;
        expect_cnt("R10 inverted polarity");
        trig_inv = 1'b0;
        step(8);

        // R6: prescaler ratios
        psc_code = 2'b01;
        step(6);
        cnt_en = 1'b1;
        pulses(5, 6, 4, 4);
        step(8);
        cnt_en = 1'b0;
        model += 3;
        expect_cnt("R6 divide by 2");

        psc_code = 2'b10;
        step(6);
        cnt_en = 1'b1;
        pulses(5, 3, 4, 4);
        step(8);
        expect_cnt("R6 divide by 4 partial group");
        pulses(5, 5, 4, 4);
        step(8);
        cnt_en = 1'b0;
        model += 2;
        expect_cnt("R6 divide by 4");

        psc_code = 2'b11;
        step(6);
        cnt_en = 1'b1;
        pulses(5, 7, 4, 4);
        step(8);
        expect_cnt("R6 divide by 8 seven edges");
        pulses(5, 9, 4, 4);
        step(8);
        cnt_en = 1'b0;
        model += 2;
        expect_cnt("R6 divide by 8");
        psc_code = 2'b00;
        step(6);

        // R7: filter rejects short pulses
        flt_code = 4'd1;
        step(6);
        cnt_en = 1'b1;
        pulses(5, 1, 1, 6);
        step(6);
        expect_cnt("R7 code 1 glitch rejected");
        pulses(5, 1, 4, 6);
        step(8);
        model += 1;
        expect_cnt("R7 code 1 pulse passed");
        cnt_en = 1'b0;
        flt_code = 4'd3;
        step(6);
        cnt_en = 1'b1;
        pulses(5, 1, 5, 10);
        step(8);
        expect_cnt("R7 code 3 five-cycle pulse rejected");
        pulses(5, 1, 8, 10);
        step(10);
        cnt_en = 1'b0;
        model += 1;
        expect_cnt("R7 code 3 long pulse passed");
        flt_code = 4'd0;
        ext_mode = 1'b0;
        step(4);

        // R8: wrap through internal counting
        cnt_en = 1'b1;
        step(65535 - model);
        cnt_en = 1'b0;
        model = 65535;
        step(1);
        expect_cnt("R8 reaches FFFF");
        cnt_en = 1'b1;
        step(1);
        cnt_en = 1'b0;
        model = 0;
        step(1);
        expect_cnt("R8 wraps to 0");

        step(2);
        done = 1'b1;
        finish_run();
    end
endmodule